// File: doc/BRIEF.md
# Run-Length Trace Stream Decompressor

This block rebuilds a per-clock sample sequence from a change-only trace. A capture engine records a sample only when it changes, and otherwise records how many extra clocks the previous value lasted. Each incoming word carries a type flag in its most significant bit and a payload in the bits below it. A literal word carries a new sample. A run word carries a repeat count for the most recently stored sample. The decompressor takes these words through a valid/ready input handshake and puts out one reconstructed sample per beat through a valid/ready output handshake.

If a stream opens with a run word, no sample value is known yet. The repeated beats then carry an "unknown" sideband bit and zero data. A zero repeat count and two run words in a row are both protocol faults. Each is reported through its own sticky flag. A synchronous restart input clears everything so that a new stream can begin. An end-of-stream marker on the input produces a one-cycle completion pulse once every sample from that word has been delivered.

The controller is a three-state machine:
- ST_IDLE waits for a word, with input ready high.
- ST_LIT presents a literal sample.
- ST_RUN presents repeated samples from a down-counter.

The transitions are:
- IDLE→LIT on an accepted literal.
- IDLE→RUN on an accepted run word with a nonzero count.
- IDLE→IDLE on an accepted zero-count run word.
- LIT→IDLE when the literal beat is taken.
- RUN→RUN while more than one repeat remains.
- RUN→IDLE when the final repeat beat is taken.
- Any state→IDLE on restart.

Top module: `rld_decomp`

## Requirements
- R1: After reset, out_valid, stream_done, err_zero_run and err_double_run are 0 and in_ready is 1.
- R2: A word whose top bit (bit PAYLOAD_W, bit 31 at default width) is 0 yields exactly one output beat with out_sample equal to the low PAYLOAD_W bits and out_unknown 0. That value becomes the stored sample.
- R3: A word whose top bit is 1 and whose payload N is at least 1 yields exactly N further beats of the stored sample.
- R4: A run word with payload 0 yields no output beat and sets err_zero_run, which stays set until restart or reset.
- R5: An all-ones run count (2^PAYLOAD_W − 1) is expanded to exactly that many beats, with no special meaning.
- R6: A run word that arrives before any literal since reset or restart yields beats with out_unknown 1 and out_sample 0.
- R7: A run word that directly follows another run word sets err_double_run, which stays set until restart or reset. The word is still expanded against the stored sample.
- R8: in_ready is 0 while any output beat is pending. The next word is accepted only after the final beat of the current word has been taken.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_sample and out_unknown hold. Beats leave in input word order, with no beat dropped or duplicated under any out_ready pattern.
- R10: A cycle with restart high clears the stored sample, its known state, both error flags, the pending repeats and any pending end-of-stream. in_ready is 0 during that cycle.
- R11: When a word is accepted with in_last 1, stream_done pulses for one cycle in the cycle after its final beat. For a zero-count run word, the pulse comes in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Synchronous start-of-new-stream clear |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word ready |
| in_word | input | PAYLOAD_W+1 | Flag bit on top, payload below |
| in_last | input | 1 | Marks the final word of a stream |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Output sample ready |
| out_sample | output | PAYLOAD_W | Reconstructed sample |
| out_unknown | output | 1 | Sample value is not known |
| stream_done | output | 1 | One-cycle end-of-stream pulse |
| err_zero_run | output | 1 | Sticky zero-count fault |
| err_double_run | output | 1 | Sticky consecutive-run fault |

## Verification
The bench builds the block with PAYLOAD_W set to 8. This puts the saturated count of 255 repeats within a short run, so the all-ones expansion is checked beat by beat instead of being assumed. The narrow payload also lets a full stall pattern run across a complete saturated expansion. Every other behaviour is independent of width, so the default 31-bit build differs only in counter length.

// File: rtl/rld_pkg.sv
package rld_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LIT  = 2'd1,
        ST_RUN  = 2'd2
    } rld_state_e;
endpackage

// File: rtl/rld_word_split.sv
module rld_word_split #(
    parameter int PAYLOAD_W = 31
) (
    input  logic [PAYLOAD_W:0]   word,
    output logic                 is_run,
    output logic                 zero_run,
    output logic [PAYLOAD_W-1:0] payload
);
    assign is_run   = word[PAYLOAD_W];
    assign payload  = word[PAYLOAD_W-1:0];
    assign zero_run = is_run && (payload == '0);
endmodule

// File: rtl/rld_run_ctr.sv
module rld_run_ctr #(
    parameter int PAYLOAD_W = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 load,
    input  logic [PAYLOAD_W-1:0] load_val,
    input  logic                 dec,
    output logic [PAYLOAD_W-1:0] remain,
    output logic                 final_beat
);
    localparam logic [PAYLOAD_W-1:0] ONE = {{(PAYLOAD_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec) begin
            remain <= remain - ONE;
        end
    end

    assign final_beat = (remain == ONE);

    // R3: a repeat beat is never taken with no repeats left
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (remain != '0));
endmodule

// File: rtl/rld_decomp.sv
module rld_decomp #(
    parameter int PAYLOAD_W = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [PAYLOAD_W:0]   in_word,
    input  logic                 in_last,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [PAYLOAD_W-1:0] out_sample,
    output logic                 out_unknown,
    output logic                 stream_done,
    output logic                 err_zero_run,
    output logic                 err_double_run
);
    import rld_pkg::*;

    rld_state_e state_q, state_d;

    logic                 w_run, w_zero;
    logic [PAYLOAD_W-1:0] w_payload;
    logic [PAYLOAD_W-1:0] run_left;
    logic                 run_final;
    logic [PAYLOAD_W-1:0] value_q;
    logic                 known_q, prev_run_q, last_pend_q, done_q;
    logic                 errz_q, errd_q;
    logic                 accept, beat, word_done;

    rld_word_split #(.PAYLOAD_W(PAYLOAD_W)) u_split (
        .word     (in_word),
        .is_run   (w_run),
        .zero_run (w_zero),
        .payload  (w_payload)
    );

    rld_run_ctr #(.PAYLOAD_W(PAYLOAD_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (restart),
        .load       (accept && w_run && !w_zero),
        .load_val   (w_payload),
        .dec        (beat && (state_q == ST_RUN)),
        .remain     (run_left),
        .final_beat (run_final)
    );

    assign accept    = in_valid && in_ready;
    assign beat      = out_valid && out_ready;
    assign word_done = beat && ((state_q == ST_LIT) || run_final);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!w_run)       state_d = ST_LIT;
                    else if (!w_zero) state_d = ST_RUN;
                end
            end
            ST_LIT:  if (out_ready) state_d = ST_IDLE;
            ST_RUN:  if (out_ready && run_final) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (restart) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        in_ready       = (state_q == ST_IDLE) && !restart;
        out_valid      = (state_q != ST_IDLE);
        out_unknown    = (state_q == ST_RUN) && !known_q;
        out_sample     = (out_valid && known_q) ? value_q : '0;
        stream_done    = done_q;
        err_zero_run   = errz_q;
        err_double_run = errd_q;
    end

    // stored sample, fault flags and end-of-stream tracking
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            value_q     <= '0;
            known_q     <= 1'b0;
            prev_run_q  <= 1'b0;
            last_pend_q <= 1'b0;
            done_q      <= 1'b0;
            errz_q      <= 1'b0;
            errd_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (!w_run) begin
                    value_q    <= w_payload;
                    known_q    <= 1'b1;
                    prev_run_q <= 1'b0;
                end else begin
                    prev_run_q <= 1'b1;
                    if (prev_run_q) errd_q <= 1'b1;
                    if (w_zero)     errz_q <= 1'b1;
                end
                if (in_last) begin
                    if (w_zero) done_q      <= 1'b1;
                    else        last_pend_q <= 1'b1;
                end
            end
            if (word_done && last_pend_q) begin
                done_q      <= 1'b1;
                last_pend_q <= 1'b0;
            end
        end
    end

    // R9: a stalled beat holds its value
    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !restart) |=>
            (out_valid && $stable(out_sample) && $stable(out_unknown)));

    // R8: an accepted word with output keeps the input closed next cycle
    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !w_zero && !restart) |=> (out_valid && !in_ready));

    // R6: unknown beats carry zero data
    p_unknown_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_unknown) |-> (out_sample == '0));

    // R4: zero-count fault is sticky
    p_zero_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_zero_run && !restart) |=> err_zero_run);

    // R7: consecutive-run fault is sticky
    p_double_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_double_run && !restart) |=> err_double_run);

    // R11: completion is only reported with no beat outstanding
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stream_done |-> !out_valid);
endmodule

// File: tb/rld_decomp_bench.sv
module rld_decomp_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         restart = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W:0]   in_word = '0;
    logic         in_last = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [W-1:0] out_sample;
    logic         out_unknown;
    logic         stream_done;
    logic         err_zero_run;
    logic         err_double_run;

    int n_chk = 0;
    int n_bad = 0;

    logic [W-1:0] cap_d [0:511];
    logic         cap_u [0:511];
    int           cap_n = 0;
    logic [W-1:0] exp_d [0:511];
    logic         exp_u [0:511];
    int           exp_n = 0;
    int           done_hits = 0;
    int           done_at = -1;
    logic         stall_en = 1'b0;
    int           pat = 0;

    always #5 clk = ~clk;

    rld_decomp #(.PAYLOAD_W(W)) u_rld_decomp (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
        .out_unknown(out_unknown), .stream_done(stream_done),
        .err_zero_run(err_zero_run), .err_double_run(err_double_run)
    );

    always @(posedge clk) begin
        #3;
        pat = pat + 1;
        out_ready = !stall_en || ((pat % 3) != 0);
    end

    always @(negedge clk) begin
        if (out_valid && out_ready && cap_n < 512) begin
            cap_d[cap_n] = out_sample;
            cap_u[cap_n] = out_unknown;
            cap_n = cap_n + 1;
        end
        if (stream_done) begin
            done_hits = done_hits + 1;
            done_at = cap_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clear_bufs();
        cap_n = 0; exp_n = 0; done_hits = 0; done_at = -1;
    endtask

    task automatic expect_beat(input logic [W-1:0] d, input logic u);
        exp_d[exp_n] = d; exp_u[exp_n] = u; exp_n++;
    endtask

    task automatic send(input logic run, input logic [W-1:0] pl, input logic last);
        @(posedge clk); #1;
        in_valid = 1'b1; in_word = {run, pl}; in_last = last;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic drain();
        repeat (2) @(negedge clk);
        while (!(in_ready && !out_valid)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic cmp_stream(input string req);
        chk(cap_n == exp_n, req, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            chk(cap_d[i] == exp_d[i], req, int'(cap_d[i]), int'(exp_d[i]));
            chk(cap_u[i] == exp_u[i], req, int'(cap_u[i]), int'(exp_u[i]));
        end
    endtask

    task automatic do_restart();
        @(posedge clk); #1 restart = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R10 ready low in restart", int'(in_ready), 0);
        @(posedge clk); #1 restart = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1, "R1 in_ready", int'(in_ready), 1);
        chk(stream_done == 0, "R1 done", int'(stream_done), 0);
        chk(err_zero_run == 0 && err_double_run == 0, "R1 errors",
            int'({err_zero_run, err_double_run}), 0);
    endtask

    task automatic t_literals();
        clear_bufs(); stall_en = 1'b1;
        send(0, 8'h11, 0); send(0, 8'h22, 0); send(0, 8'h33, 0);
        drain();
        expect_beat(8'h11, 0); expect_beat(8'h22, 0); expect_beat(8'h33, 0);
        cmp_stream("R2/R9 literals");
    endtask

    task automatic t_repeat();
        clear_bufs(); stall_en = 1'b0;
        send(0, 8'h5A, 0);
        send(1, 8'd3, 0);
        @(negedge clk);
        chk(in_ready == 0 && out_valid == 1, "R8 ready low during run",
            int'(in_ready), 0);
        send(0, 8'h66, 0);
        drain();
        expect_beat(8'h5A, 0);
        for (int i = 0; i < 3; i++) expect_beat(8'h5A, 0);
        expect_beat(8'h66, 0);
        cmp_stream("R3/R8 repeat");
    endtask

    task automatic t_zero();
        clear_bufs();
        send(0, 8'h07, 0);
        send(1, 8'd0, 0);
        drain();
        expect_beat(8'h07, 0);
        cmp_stream("R4 zero run emits nothing");
        chk(err_zero_run == 1, "R4 err_zero_run", int'(err_zero_run), 1);
        send(0, 8'h08, 0);
        drain();
        chk(err_zero_run == 1, "R4 sticky", int'(err_zero_run), 1);
    endtask

    task automatic t_double();
        clear_bufs();
        send(0, 8'h44, 0);
        send(1, 8'd1, 0);
        chk(err_double_run == 0, "R7 no fault on single run", int'(err_double_run), 0);
        send(1, 8'd2, 0);
        drain();
        for (int i = 0; i < 4; i++) expect_beat(8'h44, 0);
        cmp_stream("R7 double run expanded");
        chk(err_double_run == 1, "R7 err_double_run", int'(err_double_run), 1);
    endtask

    task automatic t_leading();
        do_restart();
        @(negedge clk);
        chk(err_zero_run == 0 && err_double_run == 0, "R10 errors cleared",
            int'({err_zero_run, err_double_run}), 0);
        clear_bufs();
        send(1, 8'd2, 0);
        drain();
        expect_beat(8'h00, 1); expect_beat(8'h00, 1);
        cmp_stream("R6/R10 leading run unknown");
        chk(err_double_run == 0, "R10 prior run forgotten", int'(err_double_run), 0);
        send(0, 8'h9C, 0);
        send(1, 8'd1, 0);
        drain();
        expect_beat(8'h9C, 0); expect_beat(8'h9C, 0);
        cmp_stream("R6 known after literal");
    endtask

    task automatic t_sat();
        do_restart();
        clear_bufs(); stall_en = 1'b1;
        send(0, 8'hC3, 0);
        send(1, 8'hFF, 0);
        drain();
        stall_en = 1'b0;
        for (int i = 0; i < 256; i++) expect_beat(8'hC3, 0);
        cmp_stream("R5/R9 saturated run");
    endtask

    task automatic t_done();
        do_restart();
        clear_bufs();
        send(0, 8'h12, 1);
        drain();
        chk(done_hits == 1, "R11 done after literal", done_hits, 1);
        chk(done_at == 1, "R11 done after final beat", done_at, 1);
        clear_bufs(); stall_en = 1'b1;
        send(0, 8'h34, 0);
        send(1, 8'd3, 1);
        drain();
        stall_en = 1'b0;
        chk(done_hits == 1, "R11 done after run", done_hits, 1);
        chk(done_at == 4, "R11 done after last repeat", done_at, 4);
        clear_bufs();
        send(1, 8'd0, 1);
        drain();
        chk(done_hits == 1, "R11 done on zero run", done_hits, 1);
        chk(cap_n == 0, "R11 zero run no beats", cap_n, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_literals();
        t_repeat();
        t_zero();
        t_double();
        t_leading();
        t_sat();
        t_done();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule